// File: doc/BRIEF.md
# Cascadable Dual Modulo Timer

This block holds two 8-bit up-counting timers. Each timer has a modulo register and a match comparator. A timer advances once per count pulse while it is enabled. When a pulse arrives with the counter equal to the modulo value, the counter returns to zero and a single-cycle match fires. The match latches that timer's interrupt request flag, and the flag stays set until an acknowledge clears it.

Both timers take their count pulse from one free-running prescaler. The first timer can instead count rising edges of an external pin, which is synchronized before use. The second timer can instead count the first timer's matches, so the two form one longer chain. The second timer is already enabled when reset ends. It therefore measures the oscillator settling delay, and its first match raises a program-start release that stays high until the next reset.

Software writes modulo values and control fields through a plain write strobe. A control write can also clear a timer's counter.

Top module: `dual_mod_timer`

## Requirements
- R1: Each counter is CW bits wide, is 0 after reset and adds one per selected count pulse only while its enable bit is 1. While the enable bit is 0, pulses leave the counter unchanged.
- R2: Both modulo registers reset to all ones. A pulse that finds the counter equal to the modulo value returns the counter to 0 at the same edge, so one counting cycle spans modulo+1 pulses.
- R3: A match sets that timer's bit in `irq` (bit 0 for timer 0, bit 1 for timer 1). The bit stays set until the matching `irq_ack` bit is high at a clock edge. When a match and an acknowledge meet at the same edge, the bit stays set.
- R4: A control write with bit 3 set clears that timer's counter to 0 at the write edge, whatever the enable and pulse state.
- R5: Timer 0 pulse select (control bits [1:0]): 0 is clk/2^T0_LG0, 1 is clk/2^T0_LG1, 2 is clk/2^T0_LG2, 3 is the external pin.
- R6: Timer 1 pulse select: 0 is clk/2^T1_LG0, 1 is clk/2^T1_LG1, 2 is clk/2^T1_LG2, 3 is timer 0's match pulse (cascade).
- R7: After reset, timer 1 is enabled with select 0 and timer 0 is disabled. `prog_start` rises together with timer 1's first match and then stays 1 until reset.
- R8: The external pin passes through two synchronizer flops and a rising-edge detector. Each low-to-high transition gives exactly one count, and the counter shows it at the third clock edge after the pin goes high.
- R9: Writing a modulo register leaves the counter value unchanged. The new value is used from the next comparison on.
- R10: Write map (`wr_addr`): 0 is modulo of timer 0, 1 is modulo of timer 1, 2 is control of timer 0, 3 is control of timer 1. Control fields are bits [1:0] select, bit 2 enable and bit 3 counter clear. The clear bit is a strobe and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | CW | Write data |
| ext_pin | input | 1 | Asynchronous external count input for timer 0 |
| irq_ack | input | 2 | Per-timer interrupt flag clear |
| irq | output | 2 | Per-timer interrupt request flags |
| prog_start | output | 1 | Sticky release after timer 1's first match |
| cnt0 | output | CW | Timer 0 counter value |
| cnt1 | output | CW | Timer 1 counter value |

## Verification
A match setting an interrupt flag can fall in the same cycle as the acknowledge that clears the flag. The bench provokes this by putting timer 0 on the external pin with a modulo of 0, so that every pin edge is a match. It then raises the acknowledge exactly during the cycle in which the synchronized edge reaches the counter, and requires the flag to still be set afterwards. A lone acknowledge is checked separately to show that it does clear the flag.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam logic [1:0] A_MOD0  = 2'd0;
  localparam logic [1:0] A_MOD1  = 2'd1;
  localparam logic [1:0] A_CTRL0 = 2'd2;
  localparam logic [1:0] A_CTRL1 = 2'd3;
  localparam int B_EN  = 2;
  localparam int B_CLR = 3;
  localparam logic [1:0] SEL_ALT = 2'd3;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] pre
);
  always_ff @(posedge clk) begin
    if (rst) pre <= '0;
    else     pre <= pre + 1'b1;
  end
endmodule

// File: rtl/dmt_sync_edge.sv
module dmt_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [2:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[1:0], din};
  end

  // stg[1] is the second synchronizer flop, stg[2] holds its last value
  assign rise = stg[1] & ~stg[2];
endmodule

// File: rtl/dmt_pulse_sel.sv
module dmt_pulse_sel #(
  parameter int PW  = 10,
  parameter int LG0 = 8,
  parameter int LG1 = 6,
  parameter int LG2 = 4
) (
  input  logic [PW-1:0] pre,
  input  logic [1:0]    sel,
  input  logic          alt,
  output logic          pulse
);
  localparam int LGS [3] = '{LG0, LG1, LG2};
  logic [2:0] tap;

  for (genvar k = 0; k < 3; k++) begin : g_tap
    localparam logic [PW-1:0] MASK = PW'((64'd1 << LGS[k]) - 64'd1);
    assign tap[k] = ((pre & MASK) == MASK);
  end

  always_comb begin
    case (sel)
      2'd0:    pulse = tap[0];
      2'd1:    pulse = tap[1];
      2'd2:    pulse = tap[2];
      default: pulse = alt;
    endcase
  end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          pulse,
  input  logic          clr,
  input  logic [CW-1:0] modv,
  output logic [CW-1:0] cnt,
  output logic          match
);
  assign match = en && pulse && !clr && (cnt == modv);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (en && pulse)  cnt <= match ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/dual_mod_timer.sv
module dual_mod_timer
  import dmt_pkg::*;
#(
  parameter int CW     = 8,
  parameter int T0_LG0 = 8,
  parameter int T0_LG1 = 6,
  parameter int T0_LG2 = 4,
  parameter int T1_LG0 = 9,
  parameter int T1_LG1 = 10,
  parameter int T1_LG2 = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          ext_pin,
  input  logic [1:0]    irq_ack,
  output logic [1:0]    irq,
  output logic          prog_start,
  output logic [CW-1:0] cnt0,
  output logic [CW-1:0] cnt1
);
  localparam int PW = max_of(max_of(max_of(T0_LG0, T0_LG1), max_of(T0_LG2, T1_LG0)),
                             max_of(T1_LG1, T1_LG2));

  logic [PW-1:0] pre;
  logic          ext_rise;
  logic [CW-1:0] mod0_q, mod1_q;
  logic [1:0]    sel0_q, sel1_q;
  logic          en0_q, en1_q;
  logic          clr0, clr1;
  logic          pulse0, pulse1;
  logic          match0, match1;
  logic [1:0]    match;

  dmt_prescaler #(.PW(PW)) u_pre (.clk(clk), .rst(rst), .pre(pre));

  dmt_sync_edge u_sync (.clk(clk), .rst(rst), .din(ext_pin), .rise(ext_rise));

  // register file: modulo values and per-timer control
  always_ff @(posedge clk) begin
    if (rst) begin
      mod0_q <= '1;
      mod1_q <= '1;
      sel0_q <= 2'd0;
      sel1_q <= 2'd0;
      en0_q  <= 1'b0;
      en1_q  <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        A_MOD0:  mod0_q <= wr_data;
        A_MOD1:  mod1_q <= wr_data;
        A_CTRL0: begin sel0_q <= wr_data[1:0]; en0_q <= wr_data[B_EN]; end
        default: begin sel1_q <= wr_data[1:0]; en1_q <= wr_data[B_EN]; end
      endcase
    end
  end

  assign clr0 = wr_en && (wr_addr == A_CTRL0) && wr_data[B_CLR];
  assign clr1 = wr_en && (wr_addr == A_CTRL1) && wr_data[B_CLR];

  dmt_pulse_sel #(.PW(PW), .LG0(T0_LG0), .LG1(T0_LG1), .LG2(T0_LG2)) u_sel0 (
    .pre(pre), .sel(sel0_q), .alt(ext_rise), .pulse(pulse0));

  dmt_counter #(.CW(CW)) u_cnt0 (
    .clk(clk), .rst(rst), .en(en0_q), .pulse(pulse0), .clr(clr0),
    .modv(mod0_q), .cnt(cnt0), .match(match0));

  // timer 1 can count timer 0 matches (cascade)
  dmt_pulse_sel #(.PW(PW), .LG0(T1_LG0), .LG1(T1_LG1), .LG2(T1_LG2)) u_sel1 (
    .pre(pre), .sel(sel1_q), .alt(match0), .pulse(pulse1));

  dmt_counter #(.CW(CW)) u_cnt1 (
    .clk(clk), .rst(rst), .en(en1_q), .pulse(pulse1), .clr(clr1),
    .modv(mod1_q), .cnt(cnt1), .match(match1));

  assign match = {match1, match0};

  // flags: a set in the same cycle as an acknowledge wins
  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 2'b00;
      prog_start <= 1'b0;
    end else begin
      irq        <= (irq & ~irq_ack) | match;
      prog_start <= prog_start | match1;
    end
  end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic [1:0]    irq_ack,
  input logic [1:0]    irq,
  input logic          prog_start,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic [1:0]    t_match
);
  // R1 / R2: a counter only holds, steps by one, or returns to zero
  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 1'b1 || cnt0 == '0));

  // R2 / R3: a new interrupt for timer 0 comes with a cleared counter
  assert_irq_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq[0]) |-> (cnt0 == '0));

  // R3: set wins over acknowledge
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    t_match[0] |=> irq[0]);

  // R3: acknowledge without a set clears the flag
  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[1] && !t_match[1]) |=> !irq[1]);

  // R4: clear strobe zeroes timer 0
  assert_sw_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2 && wr_data[3]) |=> (cnt0 == '0));

  // R7: release is sticky and arrives with timer 1's flag
  assert_start_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> prog_start);
  assert_start_with_irq_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_start) |-> (irq[1] && cnt1 == '0));
endmodule

bind dual_mod_timer dmt_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq_ack(irq_ack), .irq(irq), .prog_start(prog_start),
  .cnt0(cnt0), .cnt1(cnt1), .t_match(match));

// File: tb/sim_dual_mod_timer.sv
module sim_dual_mod_timer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          ext_pin = 1'b0;
  logic [1:0]    irq_ack = '0;
  logic [1:0]    irq;
  logic          prog_start;
  logic [CW-1:0] cnt0, cnt1;

  always #5 clk = ~clk;

  dual_mod_timer #(.CW(CW), .T0_LG0(3), .T0_LG1(2), .T0_LG2(1),
                   .T1_LG0(4), .T1_LG1(5), .T1_LG2(3)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_pin(ext_pin), .irq_ack(irq_ack), .irq(irq), .prog_start(prog_start),
    .cnt0(cnt0), .cnt1(cnt1));

  typedef struct {
    string req;
    int    kind;   // 0 cnt0, 1 cnt1, 2 irq, 3 prog_start, 4 measured
    int    exp;
    int    act;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic int probe(input int kind);
    case (kind)
      0: return int'(cnt0);
      1: return int'(cnt1);
      2: return int'(irq);
      default: return int'(prog_start);
    endcase
  endfunction

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      int a;
      it = exp_q.pop_front();
      a = (it.kind == 4) ? it.act : probe(it.kind);
      checks++;
      if (a != it.exp) begin
        errors++;
        $display("FAIL %s actual=%0d expected=%0d", it.req, a, it.exp);
      end
    end
  end

  task automatic expect_item(input string req, input int kind, input int exp, input int act = 0);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp; it.act = act;
    exp_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_val(input int kind, input int v);
    for (int g = 0; g < 5000 && probe(kind) != v; g++) tick(1);
  endtask

  task automatic period(input int kind, input int exp, input string req);
    int prev;
    int n;
    prev = probe(kind);
    for (int g = 0; g < 5000 && probe(kind) == prev; g++) tick(1);
    prev = probe(kind);
    n = 0;
    for (int g = 0; g < 5000 && probe(kind) == prev; g++) begin tick(1); n++; end
    expect_item(req, 4, exp, n);
  endtask

  task automatic pin_pulse();
    ext_pin = 1'b1; tick(4);
    ext_pin = 1'b0; tick(4);
  endtask

  initial begin
    int n;
    int last;
    tick(5);
    rst = 1'b0;
    expect_item("R1 reset cnt0", 0, 0);
    expect_item("R1 reset cnt1", 1, 0);
    expect_item("R3 reset irq", 2, 0);
    expect_item("R7 reset prog_start", 3, 0);

    // timer 1 runs from reset at clk/16, modulo all ones: 4096 cycles
    tick(3980);
    expect_item("R7 prog_start still low before first match", 3, 0);
    expect_item("R7 timer0 disabled at reset", 0, 0);
    tick(200);
    expect_item("R7 prog_start after first timer1 match", 3, 1);
    expect_item("R2 R3 timer1 flag after 256 pulses", 2, 2);

    irq_ack = 2'b10; tick(1); irq_ack = 2'b00;
    expect_item("R3 ack clears flag", 2, 0);
    expect_item("R7 prog_start sticky", 3, 1);

    wr(2'd3, 8'h08);   // R10: clear timer 1, disable
    expect_item("R4 clear timer1", 1, 0);
    tick(100);
    expect_item("R1 disabled timer ignores pulses", 1, 0);

    wr(2'd2, 8'h04); period(0, 8, "R5 R10 timer0 sel0");
    wr(2'd2, 8'h05); period(0, 4, "R5 timer0 sel1");
    wr(2'd2, 8'h06); period(0, 2, "R5 timer0 sel2");
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h04); period(1, 16, "R6 timer1 sel0");
    wr(2'd3, 8'h05); period(1, 32, "R6 timer1 sel1");
    wr(2'd3, 8'h06); period(1, 8, "R6 timer1 sel2");
    wr(2'd3, 8'h00);

    // R2: modulo 3 at clk/2 -> wrap every 8 cycles
    irq_ack = 2'b11; tick(1); irq_ack = 2'b00;
    wr(2'd0, 8'd3);
    wr(2'd2, 8'h0E);
    wait_val(0, 3);
    wait_val(0, 0);
    expect_item("R2 R3 match sets timer0 flag", 4, 1, int'(irq[0]));
    n = 0; last = 0;
    for (int g = 0; g < 100; g++) begin
      tick(1); n++;
      if (cnt0 > 8'd3) last = 1;
      if (cnt0 == 0 && n > 1) break;
    end
    expect_item("R2 wrap interval mod+1 pulses", 4, 8, n);
    expect_item("R2 counter never exceeds modulo", 4, 0, last);

    // R6 cascade: timer1 counts timer0 matches, modulo 1
    wr(2'd1, 8'd1);
    wr(2'd3, 8'h0F);
    period(1, 8, "R6 cascade on timer0 match");
    wr(2'd3, 8'h00);
    irq_ack = 2'b11; tick(1); irq_ack = 2'b00;

    // R8 external pin
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h0F);
    ext_pin = 1'b1;
    expect_item("R8 no count before sync", 0, 0);
    tick(2);
    expect_item("R8 still zero before third edge", 0, 0);
    tick(1);
    expect_item("R8 count at third edge", 0, 1);
    tick(10);
    expect_item("R8 held level counts once", 0, 1);
    ext_pin = 1'b0; tick(5);
    pin_pulse();
    expect_item("R8 second edge counts", 0, 2);

    // R3 set wins: modulo 0 makes every pin edge a match
    wr(2'd0, 8'd0);
    wr(2'd2, 8'h0F);
    pin_pulse();
    expect_item("R3 pin match sets flag", 4, 1, int'(irq[0]));
    ext_pin = 1'b1;           // E0
    tick(2);                  // after E2: edge reaches the counter at E3
    irq_ack = 2'b01;
    tick(1);                  // after E3
    irq_ack = 2'b00;
    expect_item("R3 set wins over ack", 4, 1, int'(irq[0]));
    ext_pin = 1'b0; tick(4);
    irq_ack = 2'b01; tick(1); irq_ack = 2'b00;
    expect_item("R3 lone ack clears flag", 4, 0, int'(irq[0]));

    // R9 modulo write keeps count
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h0F);
    pin_pulse(); pin_pulse(); pin_pulse();
    expect_item("R9 count before modulo write", 0, 3);
    wr(2'd0, 8'd200);
    expect_item("R9 modulo write keeps counter", 0, 3);
    pin_pulse();
    expect_item("R9 counting continues", 0, 4);

    // R4 clear strobe
    wr(2'd2, 8'h0F);
    expect_item("R4 clear strobe zeroes timer0", 0, 0);
    pin_pulse();
    expect_item("R4 R10 clear bit not stored", 0, 1);

    tick(2);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule